// File: doc/BRIEF.md
# Microsequencer Next-Address Instruction Decoder

This block is the purely combinational control core of a microprogram sequencer. Each microcycle it takes a 4-bit sequencing opcode from the current microword, a single pass/fail bit from the condition multiplexer and a flag that reports whether the loop counter has reached zero. From these three inputs it produces every control line the address datapath needs: the next-address multiplexer select, active-low output enables for the two tri-state sources that share the direct-address bus (the mapping table and the pipeline branch field), an active-low stack enable with a push/pop direction, and active-low counter load and decrement enables.

The opcode set has sixteen entries. It covers plain continuation and unconditional jumps, conditional jumps to the pipeline, mapping or vector address, two-way branches between the holding register and the pipeline, conditional calls and returns, counter loading, and three loop forms. Two loop forms count down, taking the start address from the stack or from the pipeline. The third loop form runs until the condition passes. All outputs are plain control levels with no handshake, because the datapath consumes them in the same cycle. The block holds no state, and it needs neither a clock nor a reset.

Top module: `sq_next_decode`

## Requirements
- R1: `op` encodes, 0 to 15: ZERO, CALL_C, MAP, JUMP_C, PUSH_LDC, CALL_RP, VEC_C, JUMP_RP, LOOP_STK_CNT, LOOP_PL_CNT, RET_C, JUMP_POP_C, LOAD_CNT, LOOP_TEST, NEXT, JUMP. `src_sel` values: 0 = incremented address, 1 = holding register, 2 = stack top, 3 = direct bus. `test_ok` high means pass.
- R2: At most one of `map_oe_n` and `pipe_oe_n` is low. Either one may be low only while `src_sel` is 3. `pipe_oe_n` is high whenever the pipeline is not the chosen source.
- R3: The unconditional opcodes work as follows. ZERO selects 3 with both bus enables high, so the bus reads zero. MAP selects 3 with `map_oe_n` low. JUMP selects 3 with `pipe_oe_n` low. NEXT selects 0.
- R4: JUMP_C and VEC_C select 3 on pass, with the pipeline or the mapping source enabled respectively. On fail they select 0.
- R5: JUMP_RP and CALL_RP select 3 with the pipeline enabled on pass, and select 1 on fail. CALL_RP pushes in both cases.
- R6: CALL_C pushes and jumps to the pipeline on pass. RET_C pops and selects 2 on pass. JUMP_POP_C pops and jumps to the pipeline on pass. All three select 0 and leave the stack idle on fail.
- R7: LOAD_CNT selects 0 and drives `cnt_load_n` low. PUSH_LDC selects 0 and always pushes, and it drives `cnt_load_n` low only on pass.
- R8: When the counter is nonzero, LOOP_STK_CNT selects 2 with the stack idle and LOOP_PL_CNT selects 3 with the pipeline enabled. Both drive `cnt_dec_n` low. When the counter is zero, both select 0 and leave the counter idle, and LOOP_STK_CNT pops.
- R9: LOOP_TEST selects 2 with the stack idle on fail. On pass it selects 0 and pops.
- R10: The stack is enabled when `stk_en_n` is low. `stk_push` is 1 for a push and 0 for a pop, and it is 0 whenever the stack is idle. `cnt_load_n` and `cnt_dec_n` are high except where R7 and R8 drive them, and they are never both low.
- R11: `cnt_is_zero` has no effect on any output except under the two counting loops. `test_ok` has no effect under ZERO, MAP, JUMP, NEXT, LOAD_CNT and the counting loops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Sequencing opcode from the microword |
| test_ok | input | 1 | Condition result, high = pass |
| cnt_is_zero | input | 1 | Loop counter has reached zero |
| src_sel | output | 2 | Next-address multiplexer select |
| map_oe_n | output | 1 | Mapping source bus enable, active low |
| pipe_oe_n | output | 1 | Pipeline branch field bus enable, active low |
| stk_en_n | output | 1 | Stack operation enable, active low |
| stk_push | output | 1 | Stack direction, 1 = push, 0 = pop |
| cnt_load_n | output | 1 | Counter load enable, active low |
| cnt_dec_n | output | 1 | Counter decrement enable, active low |

## Verification
Several opcodes ask for a stack action and an address choice, or a stack action and a counter action, in the same cycle. PUSH_LDC on pass pushes and loads the counter at once. When LOOP_STK_CNT ends, it pops while it switches the select from the stack to the incremented address. The bench provokes these pairings by walking every opcode through all four combinations of `test_ok` and `cnt_is_zero`, and then through a long pseudo-random stream. A behavioural reference written from the requirements judges each cycle, comparing all seven outputs, so a missing half of any pairing shows up as a mismatch.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int OP_W  = 4;
  localparam int SEL_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ZERO         = 4'd0,
    OP_CALL_C       = 4'd1,
    OP_MAP          = 4'd2,
    OP_JUMP_C       = 4'd3,
    OP_PUSH_LDC     = 4'd4,
    OP_CALL_RP      = 4'd5,
    OP_VEC_C        = 4'd6,
    OP_JUMP_RP      = 4'd7,
    OP_LOOP_STK_CNT = 4'd8,
    OP_LOOP_PL_CNT  = 4'd9,
    OP_RET_C        = 4'd10,
    OP_JUMP_POP_C   = 4'd11,
    OP_LOAD_CNT     = 4'd12,
    OP_LOOP_TEST    = 4'd13,
    OP_NEXT         = 4'd14,
    OP_JUMP         = 4'd15
  } sq_op_e;

  typedef enum logic [SEL_W-1:0] {
    SRC_INC = 2'd0,
    SRC_REG = 2'd1,
    SRC_STK = 2'd2,
    SRC_BUS = 2'd3
  } sq_src_e;

  // which tri-state driver owns the direct bus
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_MAP  = 2'd1,
    DRV_PIPE = 2'd2
  } sq_drv_e;
endpackage

// File: rtl/sq_src_sel.sv
module sq_src_sel
  import sq_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  input  logic             test_ok,
  input  logic             cnt_is_zero,
  output logic [SEL_W-1:0] src_sel,
  output logic             map_oe_n,
  output logic             pipe_oe_n
);
  sq_src_e src;
  sq_drv_e drv;

  always_comb begin
    src = SRC_INC;
    drv = DRV_NONE;
    unique case (sq_op_e'(op))
      OP_ZERO:     src = SRC_BUS;
      OP_MAP:      begin src = SRC_BUS; drv = DRV_MAP; end
      OP_JUMP:     begin src = SRC_BUS; drv = DRV_PIPE; end
      OP_CALL_C, OP_JUMP_C, OP_JUMP_POP_C:
        if (test_ok) begin src = SRC_BUS; drv = DRV_PIPE; end
      OP_VEC_C:
        if (test_ok) begin src = SRC_BUS; drv = DRV_MAP; end
      OP_CALL_RP, OP_JUMP_RP:
        if (test_ok) begin src = SRC_BUS; drv = DRV_PIPE; end
        else src = SRC_REG;
      OP_RET_C:
        if (test_ok) src = SRC_STK;
      OP_LOOP_STK_CNT:
        if (!cnt_is_zero) src = SRC_STK;
      OP_LOOP_PL_CNT:
        if (!cnt_is_zero) begin src = SRC_BUS; drv = DRV_PIPE; end
      OP_LOOP_TEST:
        if (!test_ok) src = SRC_STK;
      default: src = SRC_INC;
    endcase
  end

  assign src_sel   = src;
  assign map_oe_n  = (drv != DRV_MAP);
  assign pipe_oe_n = (drv != DRV_PIPE);
endmodule

// File: rtl/sq_stack_ctl.sv
module sq_stack_ctl
  import sq_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            test_ok,
  input  logic            cnt_is_zero,
  output logic            stk_en_n,
  output logic            stk_push
);
  logic do_push, do_pop;

  always_comb begin
    do_push = 1'b0;
    do_pop  = 1'b0;
    unique case (sq_op_e'(op))
      OP_PUSH_LDC, OP_CALL_RP:         do_push = 1'b1;
      OP_CALL_C:                       do_push = test_ok;
      OP_RET_C, OP_JUMP_POP_C:         do_pop  = test_ok;
      OP_LOOP_TEST:                    do_pop  = test_ok;
      OP_LOOP_STK_CNT:                 do_pop  = cnt_is_zero;
      default: begin do_push = 1'b0; do_pop = 1'b0; end
    endcase
  end

  assign stk_en_n = ~(do_push | do_pop);
  assign stk_push = do_push;
endmodule

// File: rtl/sq_count_ctl.sv
module sq_count_ctl
  import sq_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            test_ok,
  input  logic            cnt_is_zero,
  output logic            cnt_load_n,
  output logic            cnt_dec_n
);
  logic ld, dec;

  always_comb begin
    ld  = 1'b0;
    dec = 1'b0;
    unique case (sq_op_e'(op))
      OP_LOAD_CNT:                      ld  = 1'b1;
      OP_PUSH_LDC:                      ld  = test_ok;
      OP_LOOP_STK_CNT, OP_LOOP_PL_CNT:  dec = ~cnt_is_zero;
      default: begin ld = 1'b0; dec = 1'b0; end
    endcase
  end

  assign cnt_load_n = ~ld;
  assign cnt_dec_n  = ~dec;
endmodule

// File: rtl/sq_next_decode.sv
module sq_next_decode
  import sq_pkg::*;
(
  input  logic [3:0] op,
  input  logic       test_ok,
  input  logic       cnt_is_zero,
  output logic [1:0] src_sel,
  output logic       map_oe_n,
  output logic       pipe_oe_n,
  output logic       stk_en_n,
  output logic       stk_push,
  output logic       cnt_load_n,
  output logic       cnt_dec_n
);
  sq_src_sel u_src (
    .op(op), .test_ok(test_ok), .cnt_is_zero(cnt_is_zero),
    .src_sel(src_sel), .map_oe_n(map_oe_n), .pipe_oe_n(pipe_oe_n)
  );

  sq_stack_ctl u_stk (
    .op(op), .test_ok(test_ok), .cnt_is_zero(cnt_is_zero),
    .stk_en_n(stk_en_n), .stk_push(stk_push)
  );

  sq_count_ctl u_cnt (
    .op(op), .test_ok(test_ok), .cnt_is_zero(cnt_is_zero),
    .cnt_load_n(cnt_load_n), .cnt_dec_n(cnt_dec_n)
  );
endmodule

// File: rtl/sq_next_decode_chk.sv
module sq_next_decode_chk (
  input logic [3:0] op,
  input logic       test_ok,
  input logic       cnt_is_zero,
  input logic [1:0] src_sel,
  input logic       map_oe_n,
  input logic       pipe_oe_n,
  input logic       stk_en_n,
  input logic       stk_push,
  input logic       cnt_load_n,
  input logic       cnt_dec_n
);
  always_comb begin
    if (!$isunknown(op)) begin
      AST_ONE_BUS_DRIVER: assert (map_oe_n | pipe_oe_n);                  // R2
      AST_DRIVER_NEEDS_BUS: assert ((map_oe_n & pipe_oe_n) || src_sel == 2'd3); // R2
      AST_CNT_EXCLUSIVE: assert (cnt_load_n | cnt_dec_n);                 // R10
      AST_IDLE_NO_PUSH: assert (!stk_en_n || !stk_push);                  // R10
      AST_DEC_ONLY_NONZERO: assert (cnt_dec_n || !cnt_is_zero);           // R8
      AST_STACK_SRC_NO_PUSH: assert (src_sel != 2'd2 || stk_en_n || !stk_push); // R6
    end
  end
endmodule

bind sq_next_decode sq_next_decode_chk u_chk (
  .op(op), .test_ok(test_ok), .cnt_is_zero(cnt_is_zero),
  .src_sel(src_sel), .map_oe_n(map_oe_n), .pipe_oe_n(pipe_oe_n),
  .stk_en_n(stk_en_n), .stk_push(stk_push),
  .cnt_load_n(cnt_load_n), .cnt_dec_n(cnt_dec_n)
);

// File: tb/sim_sq_next_decode.sv
`timescale 1ns/1ps
module sim_sq_next_decode;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic [3:0] op = 4'd14;
  logic test_ok = 1'b0, cnt_is_zero = 1'b0;
  logic [1:0] src_sel;
  logic map_oe_n, pipe_oe_n, stk_en_n, stk_push, cnt_load_n, cnt_dec_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sq_next_decode u0 (
    .op(op), .test_ok(test_ok), .cnt_is_zero(cnt_is_zero),
    .src_sel(src_sel), .map_oe_n(map_oe_n), .pipe_oe_n(pipe_oe_n),
    .stk_en_n(stk_en_n), .stk_push(stk_push),
    .cnt_load_n(cnt_load_n), .cnt_dec_n(cnt_dec_n)
  );

  // reference: expected outputs from the requirement text
  // e = {sel[1:0], map_n, pipe_n, stk_n, push, ld_n, dec_n}
  function automatic logic [7:0] model(int o, bit t, bit z);
    int sel = 0; bit mp = 1, pl = 1, push = 0, pop = 0, ld = 0, dec = 0;
    if (o == 0) sel = 3;                                   // R3
    if (o == 2) begin sel = 3; mp = 0; end                 // R3
    if (o == 15) begin sel = 3; pl = 0; end                // R3
    if ((o == 3 || o == 1 || o == 11) && t) begin sel = 3; pl = 0; end // R4 R6
    if (o == 6 && t) begin sel = 3; mp = 0; end            // R4
    if (o == 5 || o == 7) begin                            // R5
      if (t) begin sel = 3; pl = 0; end else sel = 1;
    end
    if (o == 5 || o == 4 || (o == 1 && t)) push = 1;       // R5 R6 R7
    if ((o == 10 || o == 11) && t) pop = 1;                // R6
    if (o == 10 && t) sel = 2;
    if (o == 12 || (o == 4 && t)) ld = 1;                  // R7
    if (o == 8) begin                                      // R8
      if (!z) begin sel = 2; dec = 1; end else pop = 1;
    end
    if (o == 9 && !z) begin sel = 3; pl = 0; dec = 1; end  // R8
    if (o == 13) begin                                     // R9
      if (!t) sel = 2; else pop = 1;
    end
    return {sel[1:0], mp, pl, ~(push | pop), push, ~ld, ~dec};
  endfunction

  task automatic check(string req);
    logic [7:0] got, exp;
    got = {src_sel, map_oe_n, pipe_oe_n, stk_en_n, stk_push, cnt_load_n, cnt_dec_n};
    exp = model(int'(op), test_ok, cnt_is_zero);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d t=%0b z=%0b actual=%b expected=%b",
               req, op, test_ok, cnt_is_zero, got, exp);
    end
  endtask

  function automatic string req_of(int o);
    case (o)
      0, 2, 14, 15: return "R3";
      3, 6:         return "R4";
      5, 7:         return "R5";
      1, 10, 11:    return "R6";
      4, 12:        return "R7";
      8, 9:         return "R8";
      default:      return "R9";
    endcase
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 R1");  // state while idle: NEXT opcode
    // exhaustive walk: R1 encoding for every opcode/test/zero
    for (int o = 0; o < 16; o++) begin
      for (int c = 0; c < 4; c++) begin
        @(posedge clk); #1;
        op = o[3:0]; test_ok = c[0]; cnt_is_zero = c[1];
        @(negedge clk);
        check(req_of(o));
      end
    end
    // R11: insensitive inputs toggled one cycle apart, output held
    for (int o = 0; o < 16; o++) begin
      if (o == 8 || o == 9) continue;
      @(posedge clk); #1; op = o[3:0]; test_ok = 1'b1; cnt_is_zero = 1'b0;
      @(negedge clk); check("R11");
      @(posedge clk); #1; cnt_is_zero = 1'b1;
      @(negedge clk); check("R11");
    end
    // random stream compared every clock (R2 R10 exercised throughout)
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = lfsr[3:0]; test_ok = lfsr[7]; cnt_is_zero = lfsr[11];
      @(negedge clk);
      check("R2 R10");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule